// File: doc/BRIEF.md
# Directory coherence controller

This block is the home node for a small shared-memory cluster: four processor caches share four memory blocks, and every request that needs coherence action goes through it. For each block it keeps a state (Uncached, Shared or Exclusive), a sharer vector with one bit per processor and the identifier of the owning processor. It also holds a small backing memory with one data word per block.

Caches send read, write and eviction requests on a request channel. The controller answers on an outgoing message channel with data replies, invalidates, forward requests and invalidate-and-forward requests. Caches return invalidation acknowledgements and writebacks on a response channel. All three channels use valid/ready handshakes. A read of a block held Exclusive by another cache is forwarded to the owner rather than answered from memory. A write never completes until every other copy has been acknowledged or written back. The controller serves one transaction at a time and keeps a lookup counter and a message counter.

Top module: `dircoh_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty sharer vector and no owner, the backing memory holds zero, both counters read zero, req_ready is high and out_valid is low.
- R2: A read (req_type 0) of an Uncached or Shared block, or of an Exclusive block by its own owner, gets one data reply (out_type 0) to the requester that carries the block's memory word. The requester is then a sharer of a Shared block.
- R3: A write (req_type 1) to a Shared block with sharers other than the requester sends one invalidate (out_type 1) to each of them in ascending processor order. The data reply to the writer follows only after an acknowledgement (rsp_type 0) from every one of them.
- R4: After a write completes, the block is Exclusive with the writer as the only sharer and as owner. A write to an Uncached block is answered by a data reply at once.
- R5: A read of a block held Exclusive by another processor sends a forward request (out_type 2) to the owner, with out_src naming the requester. The owner's writeback (rsp_type 1) updates memory and leaves the block Shared by owner and requester with no owner, and the controller sends no data reply of its own.
- R6: A write to a block held Exclusive by another processor sends an invalidate-and-forward (out_type 3) to the old owner. After the owner's writeback the writer gets a data reply carrying the written-back word, and ownership passes to the writer, so a chain of writers passes ownership along.
- R7: An eviction (req_type 2) from a sharer clears its bit and sends no message. An eviction that empties the vector makes the block Uncached. An eviction from the owner stores req_data into memory and makes the block Uncached.
- R8: The four blocks have independent entries. Activity on one block changes no other block's state or data.
- R9: From the cycle a request is accepted until its transaction completes, req_ready stays low. An outgoing message held with out_ready low keeps out_valid and all its fields stable.
- R10: lookup_count rises by one for each accepted request. msg_count rises by the number of completed handshakes on the request, response and outgoing channels in that cycle.
- R11: A response whose source, block or kind does not match what the current transaction waits for is accepted and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_type | input | 2 | 0 read, 1 write, 2 eviction |
| req_blk | input | 2 | Block addressed |
| req_src | input | 2 | Requesting processor |
| req_data | input | 8 | Writeback word carried by an owner eviction |
| rsp_valid | input | 1 | Response present |
| rsp_ready | output | 1 | Controller can accept a response |
| rsp_type | input | 1 | 0 invalidation acknowledgement, 1 writeback |
| rsp_blk | input | 2 | Block the response refers to |
| rsp_src | input | 2 | Responding processor |
| rsp_data | input | 8 | Writeback word |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Network accepts the message |
| out_type | output | 2 | 0 data reply, 1 invalidate, 2 forward, 3 invalidate-and-forward |
| out_blk | output | 2 | Block the message refers to |
| out_src | output | 2 | Processor whose request caused the message |
| out_dst | output | 2 | Destination processor |
| out_data | output | 8 | Memory word for data replies, zero otherwise |
| lookup_count | output | 16 | Accepted requests since reset |
| msg_count | output | 16 | Handshakes on all three channels since reset |

## Verification
The assertions take for granted that requesters hold valid and every field steady until the handshake. They also assume that caches answer only the invalidates and forwards they were sent, and that the outgoing channel eventually raises out_ready. The bench plays all four caches from directed tasks. It keeps every request and response asserted until accepted and answers each invalidate or forward with exactly one acknowledgement or writeback. The only departures it makes are deliberate: stray responses with a wrong source or block, and one stretch with out_ready held low.

// File: rtl/dircoh_pkg.sv
package dircoh_pkg;

  typedef enum logic [1:0] {
    BLK_UNC = 2'd0,
    BLK_SHR = 2'd1,
    BLK_EXC = 2'd2
  } blk_state_e;

  typedef enum logic [1:0] {
    RQ_READ  = 2'd0,
    RQ_WRITE = 2'd1,
    RQ_EVICT = 2'd2,
    RQ_NONE  = 2'd3
  } req_kind_e;

  typedef enum logic {
    RS_ACK = 1'b0,
    RS_WB  = 1'b1
  } rsp_kind_e;

  typedef enum logic [1:0] {
    MS_DATA   = 2'd0,
    MS_INV    = 2'd1,
    MS_FWD    = 2'd2,
    MS_INVFWD = 2'd3
  } msg_kind_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_LOOK = 3'd1,
    S_INV  = 3'd2,
    S_ACKW = 3'd3,
    S_FWD  = 3'd4,
    S_WBW  = 3'd5,
    S_DATA = 3'd6
  } ctl_state_e;

endpackage

// File: rtl/dircoh_table.sv
module dircoh_table
  import dircoh_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 4,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NBLK)-1:0]  rd_blk,
  output blk_state_e               rd_state,
  output logic [NPROC-1:0]         rd_sharers,
  output logic [$clog2(NPROC)-1:0] rd_owner,
  output logic [DW-1:0]            rd_data,
  input  logic                     ent_we,
  input  logic [$clog2(NBLK)-1:0]  ent_blk,
  input  blk_state_e               ent_state,
  input  logic [NPROC-1:0]         ent_sharers,
  input  logic [$clog2(NPROC)-1:0] ent_owner,
  input  logic                     mem_we,
  input  logic [$clog2(NBLK)-1:0]  mem_blk,
  input  logic [DW-1:0]            mem_wdata
);
  localparam int BW = $clog2(NBLK);
  localparam int PW = $clog2(NPROC);

  blk_state_e       st_q  [NBLK];
  logic [NPROC-1:0] sh_q  [NBLK];
  logic [PW-1:0]    own_q [NBLK];
  logic [DW-1:0]    mem_q [NBLK];

  for (genvar b = 0; b < NBLK; b++) begin : g_entry
    logic ent_en;
    logic mem_en;
    assign ent_en = ent_we && (ent_blk == BW'(b));
    assign mem_en = mem_we && (mem_blk == BW'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[b]  <= BLK_UNC;
        sh_q[b]  <= '0;
        own_q[b] <= '0;
      end else if (ent_en) begin
        st_q[b]  <= ent_state;
        sh_q[b]  <= ent_sharers;
        own_q[b] <= ent_owner;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[b] <= '0;
      end else if (mem_en) begin
        mem_q[b] <= mem_wdata;
      end
    end
  end

  assign rd_state   = st_q[rd_blk];
  assign rd_sharers = sh_q[rd_blk];
  assign rd_owner   = own_q[rd_blk];
  assign rd_data    = mem_q[rd_blk];

endmodule

// File: rtl/dircoh_pick.sv
module dircoh_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0]         vec,
  output logic [$clog2(N)-1:0] idx
);
  localparam int W = $clog2(N);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end

endmodule

// File: rtl/dircoh_count.sv
module dircoh_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lookup_inc,
  input  logic [1:0]    msg_inc,
  output logic [CW-1:0] lookup_q,
  output logic [CW-1:0] msg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lookup_q <= '0;
    end else if (lookup_inc) begin
      lookup_q <= lookup_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_q <= '0;
    end else if (msg_inc != 2'd0) begin
      msg_q <= msg_q + CW'(msg_inc);
    end
  end

endmodule

// File: rtl/dircoh_ctrl.sv
module dircoh_ctrl
  import dircoh_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 4,
  parameter int DW    = 8,
  parameter int CW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_type,
  input  logic [$clog2(NBLK)-1:0]  req_blk,
  input  logic [$clog2(NPROC)-1:0] req_src,
  input  logic [DW-1:0]            req_data,
  input  logic                     rsp_valid,
  output logic                     rsp_ready,
  input  logic                     rsp_type,
  input  logic [$clog2(NBLK)-1:0]  rsp_blk,
  input  logic [$clog2(NPROC)-1:0] rsp_src,
  input  logic [DW-1:0]            rsp_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [1:0]               out_type,
  output logic [$clog2(NBLK)-1:0]  out_blk,
  output logic [$clog2(NPROC)-1:0] out_src,
  output logic [$clog2(NPROC)-1:0] out_dst,
  output logic [DW-1:0]            out_data,
  output logic [CW-1:0]            lookup_count,
  output logic [CW-1:0]            msg_count
);
  localparam int BW = $clog2(NBLK);
  localparam int PW = $clog2(NPROC);

  // transaction registers
  ctl_state_e       state_q, state_d;
  req_kind_e        kind_q;
  logic [BW-1:0]    blk_q;
  logic [PW-1:0]    src_q;
  logic [DW-1:0]    data_q;
  logic [NPROC-1:0] send_q, send_d;
  logic [NPROC-1:0] ack_q, ack_d;

  // directory table interface
  blk_state_e       rd_state;
  logic [NPROC-1:0] rd_sharers;
  logic [PW-1:0]    rd_owner;
  logic [DW-1:0]    rd_data;
  logic             ent_we;
  blk_state_e       ent_state;
  logic [NPROC-1:0] ent_sharers;
  logic [PW-1:0]    ent_owner;
  logic             mem_we;
  logic [DW-1:0]    mem_wdata;

  logic             req_fire, rsp_fire, out_fire, cap_en;
  logic [NPROC-1:0] src_bit, others, own_bit;
  logic             owner_other, ack_hit, wb_hit;
  logic [PW-1:0]    pick_idx;

  dircoh_table #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_blk(blk_q), .rd_state(rd_state), .rd_sharers(rd_sharers),
    .rd_owner(rd_owner), .rd_data(rd_data),
    .ent_we(ent_we), .ent_blk(blk_q), .ent_state(ent_state),
    .ent_sharers(ent_sharers), .ent_owner(ent_owner),
    .mem_we(mem_we), .mem_blk(blk_q), .mem_wdata(mem_wdata)
  );

  dircoh_pick #(.N(NPROC)) u_pick (.vec(send_q), .idx(pick_idx));

  dircoh_count #(.CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n),
    .lookup_inc(req_fire),
    .msg_inc({1'b0, req_fire} + {1'b0, rsp_fire} + {1'b0, out_fire}),
    .lookup_q(lookup_count), .msg_q(msg_count)
  );

  assign req_ready = (state_q == S_IDLE);
  assign rsp_ready = (state_q == S_INV) || (state_q == S_ACKW) || (state_q == S_WBW);
  assign req_fire  = req_valid && req_ready;
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign out_fire  = out_valid && out_ready;
  assign cap_en    = req_fire;

  assign src_bit     = NPROC'(1) << src_q;
  assign own_bit     = NPROC'(1) << rd_owner;
  assign others      = rd_sharers & ~src_bit;
  assign owner_other = (rd_state == BLK_EXC) && (rd_owner != src_q);
  assign ack_hit     = rsp_fire && (rsp_kind_e'(rsp_type) == RS_ACK) &&
                       (rsp_blk == blk_q) && ack_q[rsp_src];
  assign wb_hit      = rsp_fire && (rsp_kind_e'(rsp_type) == RS_WB) &&
                       (rsp_blk == blk_q) && (rsp_src == rd_owner);

  assign out_blk = blk_q;
  assign out_src = src_q;

  // next-state logic
  always_comb begin
    state_d     = state_q;
    send_d      = send_q;
    ack_d       = ack_q & ~(ack_hit ? (NPROC'(1) << rsp_src) : NPROC'(0));
    ent_we      = 1'b0;
    ent_state   = rd_state;
    ent_sharers = rd_sharers;
    ent_owner   = rd_owner;
    mem_we      = 1'b0;
    mem_wdata   = rsp_data;
    out_valid   = 1'b0;
    out_type    = MS_DATA;
    out_dst     = src_q;
    out_data    = '0;
    unique case (state_q)
      S_IDLE: if (req_fire) state_d = S_LOOK;
      S_LOOK: begin
        state_d = S_IDLE;
        unique case (kind_q)
          RQ_READ: state_d = owner_other ? S_FWD : S_DATA;
          RQ_WRITE: begin
            if (owner_other) begin
              state_d = S_FWD;
            end else if ((rd_state == BLK_SHR) && (others != '0)) begin
              send_d  = others;
              ack_d   = others;
              state_d = S_INV;
            end else begin
              state_d = S_DATA;
            end
          end
          RQ_EVICT: begin
            if ((rd_state == BLK_EXC) && (rd_owner == src_q)) begin
              mem_we      = 1'b1;
              mem_wdata   = data_q;
              ent_we      = 1'b1;
              ent_state   = BLK_UNC;
              ent_sharers = '0;
              ent_owner   = '0;
            end else if (rd_sharers[src_q]) begin
              ent_we      = 1'b1;
              ent_sharers = others;
              ent_state   = (others == '0) ? BLK_UNC : rd_state;
            end
          end
          default: state_d = S_IDLE;
        endcase
      end
      S_INV: begin
        out_valid = 1'b1;
        out_type  = MS_INV;
        out_dst   = pick_idx;
        if (out_fire) send_d = send_q & ~(NPROC'(1) << pick_idx);
        if (send_d == '0) state_d = (ack_d == '0) ? S_DATA : S_ACKW;
      end
      S_ACKW: if (ack_d == '0) state_d = S_DATA;
      S_FWD: begin
        out_valid = 1'b1;
        out_type  = (kind_q == RQ_WRITE) ? MS_INVFWD : MS_FWD;
        out_dst   = rd_owner;
        if (out_fire) state_d = S_WBW;
      end
      S_WBW: begin
        if (wb_hit) begin
          mem_we = 1'b1;
          if (kind_q == RQ_READ) begin
            ent_we      = 1'b1;
            ent_state   = BLK_SHR;
            ent_sharers = own_bit | src_bit;
            ent_owner   = '0;
            state_d     = S_IDLE;
          end else begin
            state_d = S_DATA;
          end
        end
      end
      S_DATA: begin
        out_valid = 1'b1;
        out_type  = MS_DATA;
        out_data  = rd_data;
        if (out_fire) begin
          state_d = S_IDLE;
          if (kind_q == RQ_WRITE) begin
            ent_we      = 1'b1;
            ent_state   = BLK_EXC;
            ent_sharers = src_bit;
            ent_owner   = src_q;
          end else if (rd_state != BLK_EXC) begin
            ent_we      = 1'b1;
            ent_state   = BLK_SHR;
            ent_sharers = rd_sharers | src_bit;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      send_q  <= '0;
      ack_q   <= '0;
    end else begin
      state_q <= state_d;
      send_q  <= send_d;
      ack_q   <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= RQ_NONE;
      blk_q  <= '0;
      src_q  <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      kind_q <= req_kind_e'(req_type);
      blk_q  <= req_blk;
      src_q  <= req_src;
      data_q <= req_data;
    end
  end

endmodule

// File: rtl/dircoh_ctrl_chk.sv
module dircoh_ctrl_chk #(
  parameter int NPROC = 4,
  parameter int NBLK  = 4,
  parameter int DW    = 8,
  parameter int CW    = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     rsp_valid,
  input logic                     rsp_ready,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [1:0]               out_type,
  input logic [$clog2(NBLK)-1:0]  out_blk,
  input logic [$clog2(NPROC)-1:0] out_src,
  input logic [$clog2(NPROC)-1:0] out_dst,
  input logic [DW-1:0]            out_data,
  input logic [CW-1:0]            lookup_count,
  input logic [CW-1:0]            msg_count
);
  logic       req_hs, rsp_hs, out_hs;
  logic [1:0] hs_n;
  assign req_hs = req_valid && req_ready;
  assign rsp_hs = rsp_valid && rsp_ready;
  assign out_hs = out_valid && out_ready;
  assign hs_n   = {1'b0, req_hs} + {1'b0, rsp_hs} + {1'b0, out_hs};

  p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_hs |=> !req_ready);

  p_busy_while_sending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);

  p_out_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_type) && $stable(out_dst)
                                   && $stable(out_blk) && $stable(out_src) && $stable(out_data)));

  p_lookup_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_hs |=> (lookup_count == $past(lookup_count) + CW'(1)));

  p_lookup_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_hs |=> $stable(lookup_count));

  p_msg_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (msg_count == $past(msg_count) + CW'($past(hs_n))));

  p_inv_other_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_type == 2'd1) |-> (out_dst != out_src));

  p_fwd_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_type[1]) |-> (out_dst != out_src));

  p_ctl_data_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_type != 2'd0) |-> (out_data == '0));

endmodule

bind dircoh_ctrl dircoh_ctrl_chk #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
  .out_blk(out_blk), .out_src(out_src), .out_dst(out_dst), .out_data(out_data),
  .lookup_count(lookup_count), .msg_count(msg_count)
);

// File: tb/dircoh_ctrl_test.sv
`timescale 1ns/1ps
module dircoh_ctrl_test;
  localparam int NPROC = 4;
  localparam int NBLK  = 4;
  localparam int DW    = 8;
  localparam int CW    = 16;

  localparam int RD = 0, WR = 1, EV = 2;
  localparam int ACK = 0, WB = 1;
  localparam int M_DATA = 0, M_INV = 1, M_FWD = 2, M_INVFWD = 3;

  logic clk, rst_n;
  logic req_valid, req_ready, rsp_valid, rsp_ready, out_valid, out_ready;
  logic [1:0] req_type, out_type;
  logic [1:0] req_blk, rsp_blk, out_blk;
  logic [1:0] req_src, rsp_src, out_src, out_dst;
  logic [DW-1:0] req_data, rsp_data, out_data;
  logic rsp_type;
  logic [CW-1:0] lookup_count, msg_count;

  int errors = 0, checks = 0, exp_lk = 0, exp_msg = 0;

  dircoh_ctrl #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_blk(req_blk), .req_src(req_src), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_type(rsp_type),
    .rsp_blk(rsp_blk), .rsp_src(rsp_src), .rsp_data(rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
    .out_blk(out_blk), .out_src(out_src), .out_dst(out_dst), .out_data(out_data),
    .lookup_count(lookup_count), .msg_count(msg_count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic send_req(input int kind, input int blk, input int src, input int data);
    @(negedge clk);
    req_valid = 1'b1; req_type = 2'(kind); req_blk = 2'(blk);
    req_src = 2'(src); req_data = DW'(data);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    exp_lk++; exp_msg++;
  endtask

  task automatic send_rsp(input int kind, input int blk, input int src, input int data);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_type = kind[0]; rsp_blk = 2'(blk);
    rsp_src = 2'(src); rsp_data = DW'(data);
    while (!rsp_ready) @(negedge clk);
    @(posedge clk);
    #1 rsp_valid = 1'b0;
    exp_msg++;
  endtask

  // waits for the next outgoing message; src < 0 skips the source check
  task automatic expect_msg(input int typ, input int dst, input int blk, input int data,
                            input int src, input string tag);
    int n;
    n = 0;
    @(negedge clk);
    while (!out_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
    if (!out_valid) begin
      chk(tag, "message present", 0, 1);
    end else begin
      exp_msg++;
      chk(tag, "type", int'(out_type), typ);
      chk(tag, "dest", int'(out_dst), dst);
      chk(tag, "block", int'(out_blk), blk);
      if (typ == M_DATA) chk(tag, "data", int'(out_data), data);
      if (src >= 0) chk(tag, "source", int'(out_src), src);
    end
  endtask

  task automatic quiet(input int n, input string tag);
    int seen;
    seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (out_valid) seen = 1;
    end
    chk(tag, "no message", seen, 0);
  endtask

  task automatic check_counters(input string tag);
    repeat (2) @(negedge clk);
    chk(tag, "lookup_count", int'(lookup_count), exp_lk);
    chk(tag, "msg_count", int'(msg_count), exp_msg);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "req_ready", int'(req_ready), 1);
    chk("R1", "out_valid", int'(out_valid), 0);
    chk("R1", "lookup_count", int'(lookup_count), 0);
    chk("R1", "msg_count", int'(msg_count), 0);
  endtask

  task automatic t_readers;
    send_req(RD, 0, 0, 0);
    expect_msg(M_DATA, 0, 0, 0, -1, "R1 R2 first read");
    check_counters("R10 after first read");
    send_req(RD, 0, 1, 0);
    expect_msg(M_DATA, 1, 0, 0, -1, "R2 second reader");
    send_req(RD, 0, 2, 0);
    expect_msg(M_DATA, 2, 0, 0, -1, "R2 third reader");
  endtask

  task automatic t_write_shared;
    send_req(WR, 0, 1, 0);
    expect_msg(M_INV, 0, 0, 0, 1, "R3 inv p0");
    expect_msg(M_INV, 2, 0, 0, 1, "R3 inv p2");
    quiet(3, "R3 no reply before acks");
    send_rsp(ACK, 0, 0, 0);
    quiet(3, "R3 no reply after one ack");
    send_rsp(ACK, 0, 2, 0);
    expect_msg(M_DATA, 1, 0, 0, -1, "R3 R4 reply after acks");
  endtask

  task automatic t_forward_read;
    send_req(RD, 0, 3, 0);
    expect_msg(M_FWD, 1, 0, 0, 3, "R5 forward to owner");
    send_rsp(WB, 0, 1, 8'hFF);
    quiet(3, "R5 no reply from controller");
    send_req(RD, 0, 2, 0);
    expect_msg(M_DATA, 2, 0, 8'hFF, -1, "R5 memory updated");
    send_req(WR, 0, 0, 0);
    expect_msg(M_INV, 1, 0, 0, 0, "R5 sharer p1");
    expect_msg(M_INV, 2, 0, 0, 0, "R5 sharer p2");
    expect_msg(M_INV, 3, 0, 0, 0, "R5 sharer p3");
    send_rsp(ACK, 0, 3, 0);
    send_rsp(ACK, 0, 1, 0);
    send_rsp(ACK, 0, 2, 0);
    expect_msg(M_DATA, 0, 0, 8'hFF, -1, "R3 reply after three acks");
  endtask

  task automatic t_owner_chain;
    send_req(WR, 0, 2, 0);
    expect_msg(M_INVFWD, 0, 0, 0, 2, "R6 invfwd to p0");
    send_rsp(WB, 0, 3, 8'h11);
    quiet(4, "R11 wrong-source writeback ignored");
    send_rsp(WB, 0, 0, 8'h5A);
    expect_msg(M_DATA, 2, 0, 8'h5A, -1, "R6 reply with writeback");
    send_req(WR, 0, 3, 0);
    expect_msg(M_INVFWD, 2, 0, 0, 3, "R6 chain to p2");
    send_rsp(WB, 0, 2, 8'h77);
    expect_msg(M_DATA, 3, 0, 8'h77, -1, "R6 chain reply");
  endtask

  task automatic t_evictions;
    send_req(EV, 0, 3, 8'h99);
    quiet(4, "R7 owner eviction silent");
    send_req(RD, 0, 1, 0);
    expect_msg(M_DATA, 1, 0, 8'h99, -1, "R7 owner eviction stored");
    send_req(EV, 0, 1, 0);
    quiet(3, "R7 sharer eviction silent");
    send_req(WR, 0, 2, 0);
    expect_msg(M_DATA, 2, 0, 8'h99, -1, "R7 R4 emptied block writes at once");
    send_req(RD, 1, 0, 0);
    expect_msg(M_DATA, 0, 1, 0, -1, "R8 block1 untouched");
    send_req(RD, 1, 1, 0);
    expect_msg(M_DATA, 1, 1, 0, -1, "R2 block1 second reader");
    send_req(EV, 1, 0, 0);
    send_req(WR, 1, 2, 0);
    expect_msg(M_INV, 1, 1, 0, 2, "R7 only remaining sharer invalidated");
    send_rsp(ACK, 0, 1, 0);
    quiet(3, "R11 wrong-block ack ignored");
    send_rsp(ACK, 1, 1, 0);
    expect_msg(M_DATA, 2, 1, 0, -1, "R3 block1 reply");
  endtask

  task automatic t_independent;
    send_req(WR, 2, 0, 0);
    expect_msg(M_DATA, 0, 2, 0, -1, "R4 uncached write");
    send_req(RD, 3, 1, 0);
    expect_msg(M_DATA, 1, 3, 0, -1, "R8 block3 independent");
    send_req(RD, 2, 3, 0);
    expect_msg(M_FWD, 0, 2, 0, 3, "R8 block2 still owned");
    send_rsp(WB, 2, 0, 8'h42);
    send_req(RD, 2, 1, 0);
    expect_msg(M_DATA, 1, 2, 8'h42, -1, "R8 block2 data");
    send_req(RD, 2, 0, 0);
    expect_msg(M_DATA, 0, 2, 8'h42, -1, "R2 former owner rereads");
  endtask

  task automatic t_stall;
    int moved;
    @(negedge clk);
    out_ready = 1'b0;
    send_req(RD, 3, 0, 0);
    expect_msg(M_DATA, 0, 3, 0, -1, "R9 stalled reply");
    moved = 0;
    repeat (3) begin
      @(negedge clk);
      if (!out_valid || out_dst != 2'd0 || req_ready) moved = 1;
    end
    chk("R9", "held and busy while stalled", moved, 0);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9", "out_valid after release", int'(out_valid), 0);
    chk("R9", "req_ready after release", int'(req_ready), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; rsp_valid = 1'b0; out_ready = 1'b1;
    req_type = '0; req_blk = '0; req_src = '0; req_data = '0;
    rsp_type = 1'b0; rsp_blk = '0; rsp_src = '0; rsp_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readers();
    t_write_shared();
    t_forward_read();
    t_owner_chain();
    t_evictions();
    t_independent();
    t_stall();
    check_counters("R10 final");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule